// File: doc/BRIEF.md
# Single-Cycle Instruction Executor Datapath

This block executes one 16-bit instruction on every rising clock edge. An instruction may come with a 16-bit immediate word, which the caller presents on a separate input in the same cycle. The block holds eight 16-bit general registers and a three-flag compare status. It decodes a 6-bit opcode and performs register moves, bitwise logic, addition, subtraction, negation, shifts, memory loads, memory stores and compares.

Memory is reached through a combinational address, write-data and strobe interface. Read data is captured at the same edge that executes the load. The block does not select branch targets, hold a program counter or fetch instructions. For control opcodes it only reports that no register write takes place. Every opcode with no defined meaning stops the datapath. A stopped datapath makes no register or memory write until reset.

Top module: `insn_exec`

## Requirements
- R1: The instruction word is split into opcode = bits 5:0, destination index L = bits 8:6, first source index A = bits 11:9 and second source index B = bits 14:12. Bit 15 has no effect.
- R2: After a synchronous active-low reset, all eight registers hold 0, `cmp_flags` is 0, and `halted` and `trapped` are 0.
- R3: Register opcodes write L at the next edge, and `reg_wr` is 1 during the cycle. The opcodes are: 1 copy A, 2 A AND B, 3 A OR B, 4 A XOR B, 5 NOT A, 6 A+B, 7 A-B, 8 negate A. All arithmetic wraps modulo 2^16.
- R4: Immediate opcodes use the immediate word in place of B: 26 copy, 27 AND, 28 OR, 29 XOR, 30 add, 31 subtract, 32/33/34 shifts, 35 compare.
- R5: The shifts are 9 left, 10 logical right and 11 arithmetic right, with the amount taken from register B. Opcodes 32, 33 and 34 take the amount from the immediate. An amount of 16 or more gives 0 for the left and logical right shifts, and 16 copies of bit 15 of A for the arithmetic right shift.
- R6: Opcode 12 (load) drives `mem_rd`=1 and `mem_addr`= register A, and writes `mem_rdata` into L at the edge.
- R7: Opcode 13 (store) drives `mem_wr`=1, `mem_addr`= register L and `mem_wdata`= register A. It writes no register. `mem_rd` and `mem_wr` are never high together.
- R8: Opcodes 14 and 35 write no register. At the edge they set `cmp_flags` to bit0 = equal, bit1 = signed less-than and bit2 = unsigned less-than of A against B or the immediate. All other opcodes leave `cmp_flags` unchanged.
- R9: Opcode 0 and the control opcodes 15 to 25 and 36 to 46 keep `reg_wr`, `mem_rd` and `mem_wr` at 0 and change no register.
- R10: Opcodes 47 to 61 and 63 set `halted` at the next edge, and it stays set until reset. While it is set, `reg_wr`, `mem_rd` and `mem_wr` are 0, and no register or `cmp_flags` changes.
- R11: Opcode 62, executed while not halted, makes `trapped` 1 for exactly the following cycle.
- R12: Starting from reset, copy 123 to register 0, then add 456, then add 789 with immediates. Register 0 then holds 1368.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 16 | Instruction word executed at the next edge |
| imm | input | 16 | Immediate word that goes with `instr` |
| mem_rdata | input | 16 | Memory read data for a load |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rd | output | 1 | Load strobe |
| mem_wr | output | 1 | Store strobe |
| reg_wr | output | 1 | A general register is written at this edge |
| cmp_flags | output | 3 | Compare status {unsigned lt, signed lt, equal} |
| halted | output | 1 | Datapath stopped |
| trapped | output | 1 | One-cycle trap indication |

## Verification
Registers have no direct port, so their contents are hard to see. The bench reads them back by issuing a store with the register as source, which puts the value on `mem_wdata`. The reference model predicts every strobe and data value in every cycle. The hardest case is a write attempt after a halt. For each of the sixteen halting opcodes, the bench resets, halts, and then issues a register write, a store and a compare. It then checks that nothing reaches the ports and that the flags do not move.

// File: rtl/insn_pkg.sv
// Shared types for the instruction executor.
// Assumes 6-bit opcodes and 3-bit register indices.
package insn_pkg;
    localparam int OPW = 6;

    typedef enum logic [3:0] {
        F_PASSA, F_PASSB, F_AND, F_IOR, F_EOR, F_NOT,
        F_ADD, F_SUB, F_NEG, F_LSL, F_LSR, F_ASR
    } alu_fn_e;

    typedef struct packed {
        alu_fn_e fn;
        logic    use_imm;
        logic    rf_we;
        logic    ld;
        logic    st;
        logic    cmp;
        logic    hlt;
        logic    trp;
    } ctl_t;
endpackage

// File: rtl/insn_decode.sv
// Opcode decoder: maps the 6-bit opcode to datapath controls.
// Assumes nothing about neighbouring fields; undefined opcodes halt.
module insn_decode
    import insn_pkg::*;
(
    input  logic [OPW-1:0] opc,
    output ctl_t           ctl
);
    // Decode the opcode into a control word.
    always_comb begin
        ctl = '0;
        ctl.fn = F_PASSA;
        case (opc) inside
            6'd1:  begin ctl.fn = F_PASSA; ctl.rf_we = 1'b1; end
            6'd2:  begin ctl.fn = F_AND;   ctl.rf_we = 1'b1; end
            6'd3:  begin ctl.fn = F_IOR;   ctl.rf_we = 1'b1; end
            6'd4:  begin ctl.fn = F_EOR;   ctl.rf_we = 1'b1; end
            6'd5:  begin ctl.fn = F_NOT;   ctl.rf_we = 1'b1; end
            6'd6:  begin ctl.fn = F_ADD;   ctl.rf_we = 1'b1; end
            6'd7:  begin ctl.fn = F_SUB;   ctl.rf_we = 1'b1; end
            6'd8:  begin ctl.fn = F_NEG;   ctl.rf_we = 1'b1; end
            6'd9:  begin ctl.fn = F_LSL;   ctl.rf_we = 1'b1; end
            6'd10: begin ctl.fn = F_LSR;   ctl.rf_we = 1'b1; end
            6'd11: begin ctl.fn = F_ASR;   ctl.rf_we = 1'b1; end
            6'd12: begin ctl.ld = 1'b1;    ctl.rf_we = 1'b1; end
            6'd13: ctl.st = 1'b1;
            6'd14: ctl.cmp = 1'b1;
            6'd26: begin ctl.fn = F_PASSB; ctl.use_imm = 1'b1; ctl.rf_we = 1'b1; end
            6'd27: begin ctl.fn = F_AND;   ctl.use_imm = 1'b1; ctl.rf_we = 1'b1; end
            6'd28: begin ctl.fn = F_IOR;   ctl.use_imm = 1'b1; ctl.rf_we = 1'b1; end
            6'd29: begin ctl.fn = F_EOR;   ctl.use_imm = 1'b1; ctl.rf_we = 1'b1; end
            6'd30: begin ctl.fn = F_ADD;   ctl.use_imm = 1'b1; ctl.rf_we = 1'b1; end
            6'd31: begin ctl.fn = F_SUB;   ctl.use_imm = 1'b1; ctl.rf_we = 1'b1; end
            6'd32: begin ctl.fn = F_LSL;   ctl.use_imm = 1'b1; ctl.rf_we = 1'b1; end
            6'd33: begin ctl.fn = F_LSR;   ctl.use_imm = 1'b1; ctl.rf_we = 1'b1; end
            6'd34: begin ctl.fn = F_ASR;   ctl.use_imm = 1'b1; ctl.rf_we = 1'b1; end
            6'd35: begin ctl.cmp = 1'b1;   ctl.use_imm = 1'b1; end
            6'd62: ctl.trp = 1'b1;
            [6'd47:6'd61], 6'd63: ctl.hlt = 1'b1;
            default: ;
        endcase
    end

    // R9: store, compare, halt and trap opcodes never request a register write.
    always_comb begin
        a_r9_ctrl_no_write: assert (!(ctl.rf_we && (ctl.st || ctl.cmp || ctl.hlt || ctl.trp)));
    end
endmodule

// File: rtl/insn_alu.sv
// Combinational ALU: logic, add/sub, negate and saturating-range shifts.
// Assumes the shift amount is the full B operand; amounts >= W are out of range.
module insn_alu
    import insn_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_fn_e       fn,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  y
);
    localparam int SHW = $clog2(W);

    logic           big;
    logic [SHW-1:0] sh;
    assign big = |b[W-1:SHW];
    assign sh  = b[SHW-1:0];

    // Select the result of the requested function.
    always_comb begin
        case (fn)
            F_PASSA: y = a;
            F_PASSB: y = b;
            F_AND:   y = a & b;
            F_IOR:   y = a | b;
            F_EOR:   y = a ^ b;
            F_NOT:   y = ~a;
            F_ADD:   y = a + b;
            F_SUB:   y = a - b;
            F_NEG:   y = '0 - a;
            F_LSL:   y = big ? '0 : (a << sh);
            F_LSR:   y = big ? '0 : (a >> sh);
            F_ASR:   y = big ? {W{a[W-1]}} : W'($signed(a) >>> sh);
            default: y = a;
        endcase
    end

    // R5: an out-of-range logical shift must produce zero.
    always_comb begin
        if ((fn == F_LSL || fn == F_LSR) && big)
            a_r5_big_shift_zero: assert (y == '0);
    end
endmodule

// File: rtl/insn_regfile.sv
// General register file: one write port, three combinational read ports.
// Assumes synchronous active-low reset clears every register.
module insn_regfile #(
    parameter int W    = 16,
    parameter int NREG = 8,
    localparam int RIW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RIW-1:0] wa,
    input  logic [W-1:0]   wd,
    input  logic [RIW-1:0] ra0,
    input  logic [RIW-1:0] ra1,
    input  logic [RIW-1:0] ra2,
    output logic [W-1:0]   rd0,
    output logic [W-1:0]   rd1,
    output logic [W-1:0]   rd2
);
    logic [W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Hold or update register g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && wa == RIW'(g))
                regs[g] <= wd;
        end
    end

    assign rd0 = regs[ra0];
    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
endmodule

// File: rtl/insn_exec.sv
// Single-cycle instruction executor: decodes instr, reads registers,
// computes, and commits at the rising edge. Memory access is combinational.
// Assumes mem_rdata is valid in the same cycle as mem_rd.
module insn_exec
    import insn_pkg::*;
#(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] instr,
    input  logic [W-1:0] imm,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic         reg_wr,
    output logic [2:0]   cmp_flags,
    output logic         halted,
    output logic         trapped
);
    localparam int RIW  = $clog2(NREG);
    localparam int L_LO = OPW;
    localparam int A_LO = OPW + RIW;
    localparam int B_LO = OPW + 2 * RIW;

    ctl_t           ctl;
    logic [RIW-1:0] idx_l, idx_a, idx_b;
    logic [W-1:0]   val_l, val_a, val_b, opnd_b, alu_y, wr_data;
    logic           eq, slt, ult;

    assign idx_l = instr[L_LO +: RIW];
    assign idx_a = instr[A_LO +: RIW];
    assign idx_b = instr[B_LO +: RIW];

    insn_decode i_dec (.opc(instr[OPW-1:0]), .ctl(ctl));

    insn_regfile #(.W(W), .NREG(NREG)) i_rf (
        .clk(clk), .rst_n(rst_n),
        .we(reg_wr), .wa(idx_l), .wd(wr_data),
        .ra0(idx_l), .ra1(idx_a), .ra2(idx_b),
        .rd0(val_l), .rd1(val_a), .rd2(val_b)
    );

    assign opnd_b = ctl.use_imm ? imm : val_b;

    insn_alu #(.W(W)) i_alu (.fn(ctl.fn), .a(val_a), .b(opnd_b), .y(alu_y));

    assign wr_data   = ctl.ld ? mem_rdata : alu_y;
    assign reg_wr    = ctl.rf_we && !halted;
    assign mem_rd    = ctl.ld && !halted;
    assign mem_wr    = ctl.st && !halted;
    assign mem_addr  = ctl.st ? val_l : val_a;
    assign mem_wdata = val_a;

    assign eq  = (val_a == opnd_b);
    assign slt = ($signed(val_a) < $signed(opnd_b));
    assign ult = (val_a < opnd_b);

    // Latch the compare status on a compare opcode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_flags <= '0;
        else if (ctl.cmp && !halted)
            cmp_flags <= {ult, slt, eq};
    end

    // Sticky halt on any halting opcode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted <= 1'b0;
        else if (ctl.hlt)
            halted <= 1'b1;
    end

    // One-cycle trap indication.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trapped <= 1'b0;
        else
            trapped <= ctl.trp && !halted;
    end

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    a_r10_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_wr && !reg_wr && !mem_rd));
    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));
    a_r11_trap_from_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trapped) |-> $past(instr[OPW-1:0] == 6'd62));
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.cmp |=> $stable(cmp_flags));
endmodule

// File: tb/test_insn_exec.sv
module test_insn_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = '0, imm = '0, mem_rdata = '0;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_rd, mem_wr, reg_wr, halted, trapped;
    logic [2:0]  cmp_flags;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [15:0] m_r [8];
    logic [2:0]  m_flags;
    logic        m_halt, m_trap;

    insn_exec i_insn_exec (.*);

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int op, input int l, input int a, input int b);
        return {1'b0, 3'(b), 3'(a), 3'(l), 6'(op)};
    endfunction

    function automatic logic [15:0] calc(input int k, input logic [15:0] a, input logic [15:0] b);
        logic signed [15:0] s;
        s = a;
        case (k)
            1: return a;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return ~a;
            6: return a + b;
            7: return a - b;
            8: return 16'(0 - int'(a));
            9: return (b >= 16) ? 16'h0 : 16'(a << b);
            10: return (b >= 16) ? 16'h0 : a >> b;
            11: return (b >= 16) ? {16{a[15]}} : 16'(s >>> b);
            default: return b;
        endcase
    endfunction

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; instr = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        foreach (m_r[i]) m_r[i] = '0;
        m_flags = '0; m_halt = 0; m_trap = 0;
        chk(tag, "halted", 16'(halted), 16'd0);
        chk(tag, "trapped", 16'(trapped), 16'd0);
        chk(tag, "flags", 16'(cmp_flags), 16'd0);
    endtask

    // Drive one instruction at negedge, check combinational outputs, step model, check state.
    task automatic run(input string tag, input logic [15:0] ins, input logic [15:0] im, input logic [15:0] rd);
        int op, l, a, b, k;
        logic wrt, e_rd, e_wr;
        logic [15:0] av, bv;
        instr = ins; imm = im; mem_rdata = rd;
        op = int'(ins[5:0]); l = int'(ins[8:6]); a = int'(ins[11:9]); b = int'(ins[14:12]);
        av = m_r[a];
        bv = (op >= 26 && op <= 35) ? im : m_r[b];
        k  = (op >= 1 && op <= 14) ? op :
             (op == 26) ? 0 : (op >= 27 && op <= 29) ? op - 25 :
             (op >= 30 && op <= 31) ? op - 24 : (op >= 32 && op <= 34) ? op - 23 :
             (op == 35) ? 14 : -1;
        wrt  = ((op >= 1 && op <= 12) || (op >= 26 && op <= 34)) && !m_halt;
        e_rd = (op == 12) && !m_halt;
        e_wr = (op == 13) && !m_halt;
        #2;
        chk(tag, "reg_wr", 16'(reg_wr), 16'(wrt));
        chk(tag, "mem_rd", 16'(mem_rd), 16'(e_rd));
        chk(tag, "mem_wr", 16'(mem_wr), 16'(e_wr));
        if (e_rd) chk(tag, "rd addr", mem_addr, av);
        if (e_wr) begin
            chk(tag, "wr addr", mem_addr, m_r[l]);
            chk(tag, "wdata", mem_wdata, av);
        end
        @(posedge clk);
        if (!m_halt) begin
            if (wrt) m_r[l] = (op == 12) ? rd : calc(k, av, bv);
            if (k == 14)
                m_flags = {av < bv, $signed(av) < $signed(bv), av == bv};
        end
        m_trap = (op == 62) && !m_halt;
        if ((op >= 47 && op <= 61) || op == 63) m_halt = 1;
        @(negedge clk);
        chk(tag, "flags", 16'(cmp_flags), 16'(m_flags));
        chk(tag, "halted", 16'(halted), 16'(m_halt));
        chk(tag, "trapped", 16'(trapped), 16'(m_trap));
    endtask

    // Observe register idx through a store with A = idx.
    task automatic peek(input string tag, input int idx, input logic [15:0] exp);
        instr = enc(13, 0, idx, 0);
        #2;
        chk(tag, "peek", mem_wdata, exp);
        chk(tag, "peek model", mem_wdata, m_r[idx]);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset("R2");
        for (int i = 0; i < 8; i++) peek("R2", i, 16'h0);

        // R12: the running-sum example
        run("R12", enc(26, 0, 0, 0), 16'd123, '0);
        run("R12", enc(30, 0, 0, 0), 16'd456, '0);
        run("R12", enc(30, 0, 0, 0), 16'd789, '0);
        peek("R12", 0, 16'd1368);

        // R6 / R7: load then store
        run("R6", enc(26, 1, 0, 0), 16'h0040, '0);
        run("R6", enc(12, 2, 1, 0), '0, 16'hBEEF);
        peek("R6", 2, 16'hBEEF);
        run("R7", enc(13, 1, 2, 0), '0, '0);

        // R3: register operations
        run("R4", enc(26, 3, 0, 0), 16'h8421, '0);
        run("R4", enc(26, 4, 0, 0), 16'h00F0, '0);
        run("R4", enc(26, 5, 0, 0), 16'hFFFE, '0);
        for (int op = 1; op <= 8; op++) begin
            run("R3", enc(op, 6, 3, 4), '0, '0);
            peek("R3", 6, m_r[6]);
            run("R3", enc(op, 7, 5, 3), '0, '0);
            peek("R3", 7, m_r[7]);
        end
        run("R3", enc(7, 6, 4, 3), '0, '0);
        peek("R3", 6, 16'h00F0 - 16'h8421);

        // R4: immediate operations
        for (int op = 26; op <= 34; op++) begin
            run("R4", enc(op, 6, 3, 0), 16'h0F35, '0);
            peek("R4", 6, m_r[6]);
        end

        // R5: shifts at boundaries, register and immediate amounts
        run("R5", enc(26, 7, 0, 0), 16'h8001, '0);
        foreach (m_r[i]) ;
        begin
            int amts [6] = '{0, 1, 15, 16, 40, 16'hFFFF};
            foreach (amts[j]) begin
                run("R5", enc(26, 2, 0, 0), 16'(amts[j]), '0);
                for (int op = 9; op <= 11; op++) begin
                    run("R5", enc(op, 6, 7, 2), '0, '0);
                    peek("R5", 6, m_r[6]);
                    run("R5", enc(op + 23, 6, 7, 0), 16'(amts[j]), '0);
                    peek("R5", 6, m_r[6]);
                end
            end
        end
        run("R5", enc(34, 6, 7, 0), 16'd16, '0);
        peek("R5", 6, 16'hFFFF);

        // R8: compares, signed vs unsigned order
        run("R8", enc(26, 1, 0, 0), 16'h8000, '0);
        run("R8", enc(26, 2, 0, 0), 16'h0001, '0);
        run("R8", enc(14, 0, 1, 2), '0, '0);
        chk("R8", "signed lt only", 16'(cmp_flags), 16'b010);
        run("R8", enc(14, 0, 2, 1), '0, '0);
        chk("R8", "unsigned lt only", 16'(cmp_flags), 16'b100);
        run("R8", enc(35, 0, 2, 0), 16'h0001, '0);
        chk("R8", "equal", 16'(cmp_flags), 16'b001);
        run("R8", enc(6, 3, 1, 2), '0, '0);
        chk("R8", "flags held", 16'(cmp_flags), 16'b001);
        peek("R8", 1, 16'h8000);

        // R1: bit 15 is ignored
        run("R1", enc(6, 5, 1, 2) | 16'h8000, '0, '0);
        peek("R1", 5, 16'h8001);

        // R9: nop and control opcodes make no write
        run("R9", enc(0, 5, 0, 0), '0, '0);
        for (int op = 15; op <= 46; op++)
            if (op <= 25 || op >= 36) run("R9", enc(op, 5, 1, 2), 16'h1234, '0);
        peek("R9", 5, 16'h8001);

        // R11: trap pulse
        run("R11", enc(62, 0, 0, 0), '0, '0);
        chk("R11", "trap set", 16'(trapped), 16'd1);
        run("R11", enc(0, 0, 0, 0), '0, '0);
        chk("R11", "trap cleared", 16'(trapped), 16'd0);

        // R10: every halting opcode blocks later writes
        for (int op = 47; op <= 63; op++) begin
            if (op == 62) continue;
            do_reset("R10");
            run("R10", enc(26, 1, 0, 0), 16'h0055, '0);
            run("R10", enc(op, 0, 0, 0), '0, '0);
            chk("R10", "halt set", 16'(halted), 16'd1);
            run("R10", enc(26, 1, 0, 0), 16'h7777, '0);
            run("R10", enc(13, 1, 1, 0), '0, '0);
            run("R10", enc(12, 1, 1, 0), '0, 16'hAAAA);
            run("R10", enc(35, 0, 1, 0), 16'h0055, '0);
            chk("R10", "flags frozen", 16'(cmp_flags), 16'd0);
            run("R10", enc(62, 0, 0, 0), '0, '0);
            chk("R10", "still halted", 16'(halted), 16'd1);
        end
        do_reset("R2");
        peek("R2", 1, 16'h0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule